// File: doc/BRIEF.md
# Event-Qualified Wait Resume Controller

This block holds a sequential process in a suspended state and decides the moment it may go on. A suspend request, accepted only while the block is idle, arms the wait. From then on the block watches a vector of signals through a per-bit sensitivity mask. A change on a selected bit releases the wait only if the condition input is true in that same cycle. A down-counter loaded at the start can also end the wait after a bounded number of cycles.

The block does not respond to levels. A condition that is already true when the wait begins does nothing by itself. Only a fresh change on a selected bit, seen after the wait has started, can release it through the event route. When the wait ends, the block gives a single-cycle resume pulse together with a cause bit that names the route. The process can then issue its next suspend request.

Top module: `wait_resume_ctrl`

## Requirements
- R1: After a synchronous reset, `busy` and `resumePulse` are 0 and `resumeCause` is 0.
- R2: A `suspendReq` sampled high at a clock edge while idle makes `busy` 1 from that edge on.
- R3: While suspended, a bit that is selected and whose sampled value differs from its value at the previous edge, together with a true condition at the same edge, makes `resumePulse` 1 for the cycle after that edge, with `resumeCause` = 0 (event).
- R4: A change on a selected bit while the condition is false does not release the wait.
- R5: A condition that stays true with no change on any selected bit does not release the wait. Differences from the value held at the edge that accepted the suspend are the earliest that count.
- R6: Changes on bits that are not selected do not release the wait.
- R7: With `timeoutEn` high at the accepting edge, a wait with no qualifying event ends with `resumePulse` 1 after the (N+1)th edge following the accepting edge, where N is `timeoutVal` at that edge, and with `resumeCause` = 1 (timeout).
- R8: With `timeoutEn` low at the accepting edge, the wait never ends by time.
- R9: When `senseMask` is all zeros, `condRefMask` selects the watched bits instead.
- R10: With `condUse` low, the condition counts as true whatever `condIn` is.
- R11: If a qualifying event and timeout expiry fall on the same edge, `resumeCause` is 0 (event).
- R12: `resumePulse` lasts exactly one cycle, comes only at the end of a wait, and `busy` is 0 while it is high.
- R13: A `suspendReq` while `busy` is 1 is ignored. It neither restarts nor reloads the wait.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| suspendReq | input | 1 | Request to start a wait |
| watchSig | input | SIG_W | Signals that may be watched |
| senseMask | input | SIG_W | Per-bit sensitivity selection |
| condRefMask | input | SIG_W | Bits the condition depends on, used when senseMask is empty |
| condUse | input | 1 | 1 when a condition is present |
| condIn | input | 1 | Condition value |
| timeoutEn | input | 1 | Enables the timeout for the wait being started |
| timeoutVal | input | CNT_W | Timeout length in cycles |
| busy | output | 1 | 1 while suspended |
| resumePulse | output | 1 | One-cycle release pulse |
| resumeCause | output | 1 | 0 = event, 1 = timeout; valid with resumePulse |

## Verification
The hardest case to reach is a qualifying event that lands on exactly the edge at which the counter expires. To get there, the stimulus loads a short timeout and counts clock steps from the accepting edge. It flips a selected bit just before the edge at which expiry is due, then checks that the cause reports the event. A second case that is hard to create is a condition already true when the wait begins. The bench enters the wait with a selected bit high and the condition true, holds both steady for many cycles, and only then drives a fall and a rise. A behavioural model of the wait is compared with the outputs on every cycle of directed and random stimulus.

// File: rtl/wr_pkg.sv
package wr_pkg;
  typedef enum logic [0:0] {
    CAUSE_EVENT   = 1'b0,
    CAUSE_TIMEOUT = 1'b1
  } causeE;

  // strobes from control to datapath
  typedef struct packed {
    logic arm;  // capture history, load counter
    logic run;  // suspended: compare, count down
  } wrStrobes;
endpackage

// File: rtl/wr_datapath.sv
module wr_datapath
  import wr_pkg::*;
#(
  parameter int SIG_W = 8,
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  wrStrobes         strb,
  input  logic [SIG_W-1:0] watchSig,
  input  logic [SIG_W-1:0] senseMask,
  input  logic [SIG_W-1:0] condRefMask,
  input  logic             condUse,
  input  logic             condIn,
  input  logic             timeoutEn,
  input  logic [CNT_W-1:0] timeoutVal,
  output logic             evtHit,
  output logic             tmoHit
);
  localparam logic [CNT_W-1:0] CNT_ZERO = '0;
  localparam logic [CNT_W-1:0] CNT_ONE  = CNT_W'(1);

  logic [SIG_W-1:0] prevSig;
  logic [SIG_W-1:0] effMask;
  logic [SIG_W-1:0] changed;
  logic [CNT_W-1:0] cnt;
  logic             tmoArm;
  logic             condOk;

  always_comb begin
    effMask = (|senseMask) ? senseMask : condRefMask;
    changed = (watchSig ^ prevSig) & effMask;
    condOk  = !condUse || condIn;
    evtHit  = strb.run && (|changed) && condOk;
    tmoHit  = strb.run && tmoArm && (cnt == CNT_ZERO);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      prevSig <= '0;
      cnt     <= '0;
      tmoArm  <= 1'b0;
    end else if (strb.arm) begin
      prevSig <= watchSig;
      cnt     <= timeoutVal;
      tmoArm  <= timeoutEn;
    end else if (strb.run) begin
      prevSig <= watchSig;
      if (cnt != CNT_ZERO) cnt <= cnt - CNT_ONE;
    end
  end
endmodule

// File: rtl/wr_control.sv
module wr_control
  import wr_pkg::*;
(
  input  logic     clk,
  input  logic     rst,
  input  logic     suspendReq,
  input  logic     evtHit,
  input  logic     tmoHit,
  output wrStrobes strb,
  output logic     busy,
  output logic     resumePulse,
  output causeE    resumeCause
);
  typedef enum logic [0:0] {ST_IDLE, ST_WAIT} stateE;
  stateE state;

  always_comb begin
    strb.arm = (state == ST_IDLE) && suspendReq;
    strb.run = (state == ST_WAIT);
    busy     = (state == ST_WAIT);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state       <= ST_IDLE;
      resumePulse <= 1'b0;
      resumeCause <= CAUSE_EVENT;
    end else begin
      resumePulse <= 1'b0;
      case (state)
        ST_IDLE: if (suspendReq) state <= ST_WAIT;
        ST_WAIT: if (evtHit || tmoHit) begin
          state       <= ST_IDLE;
          resumePulse <= 1'b1;
          resumeCause <= evtHit ? CAUSE_EVENT : CAUSE_TIMEOUT;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/wait_resume_ctrl.sv
module wait_resume_ctrl
  import wr_pkg::*;
#(
  parameter int SIG_W = 8,
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             suspendReq,
  input  logic [SIG_W-1:0] watchSig,
  input  logic [SIG_W-1:0] senseMask,
  input  logic [SIG_W-1:0] condRefMask,
  input  logic             condUse,
  input  logic             condIn,
  input  logic             timeoutEn,
  input  logic [CNT_W-1:0] timeoutVal,
  output logic             busy,
  output logic             resumePulse,
  output logic             resumeCause
);
  wrStrobes strb;
  logic     evtHit;
  logic     tmoHit;
  causeE    causeQ;

  wr_datapath #(.SIG_W(SIG_W), .CNT_W(CNT_W)) u_dp (
    .clk(clk), .rst(rst), .strb(strb), .watchSig(watchSig),
    .senseMask(senseMask), .condRefMask(condRefMask), .condUse(condUse),
    .condIn(condIn), .timeoutEn(timeoutEn), .timeoutVal(timeoutVal),
    .evtHit(evtHit), .tmoHit(tmoHit)
  );

  wr_control u_ctl (
    .clk(clk), .rst(rst), .suspendReq(suspendReq), .evtHit(evtHit),
    .tmoHit(tmoHit), .strb(strb), .busy(busy), .resumePulse(resumePulse),
    .resumeCause(causeQ)
  );

  assign resumeCause = causeQ;
endmodule

// File: rtl/wr_checker.sv
module wr_checker #(
  parameter int SIG_W = 8
) (
  input logic             clk,
  input logic             rst,
  input logic             suspendReq,
  input logic [SIG_W-1:0] watchSig,
  input logic             busy,
  input logic             resumePulse,
  input logic             resumeCause
);
  AST_RESET_CLEAR: assert property (@(posedge clk)
    rst |=> (!busy && !resumePulse && !resumeCause)); // R1

  AST_START_WAIT: assert property (@(posedge clk) disable iff (rst)
    (!busy && suspendReq) |=> busy); // R2

  AST_EVENT_NEEDS_EDGE: assert property (@(posedge clk) disable iff (rst)
    (resumePulse && !resumeCause) |-> ($past(watchSig, 2) != $past(watchSig))); // R5

  AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (rst)
    resumePulse |=> !resumePulse); // R12

  AST_PULSE_ENDS_WAIT: assert property (@(posedge clk) disable iff (rst)
    resumePulse |-> (!busy && $past(busy))); // R12

  AST_BUSY_HOLDS: assert property (@(posedge clk) disable iff (rst)
    (busy && suspendReq) |=> (busy || resumePulse)); // R13
endmodule

bind wait_resume_ctrl wr_checker #(.SIG_W(SIG_W)) u_chk (
  .clk(clk), .rst(rst), .suspendReq(suspendReq), .watchSig(watchSig),
  .busy(busy), .resumePulse(resumePulse), .resumeCause(resumeCause)
);

// File: tb/sim_wait_resume_ctrl.sv
module sim_wait_resume_ctrl;
  localparam int SIG_W = 8;
  localparam int CNT_W = 16;
  localparam time CLK_PERIOD = 10ns;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic             suspendReq = 1'b0;
  logic [SIG_W-1:0] watchSig = '0;
  logic [SIG_W-1:0] senseMask = '0;
  logic [SIG_W-1:0] condRefMask = '0;
  logic             condUse = 1'b0;
  logic             condIn = 1'b0;
  logic             timeoutEn = 1'b0;
  logic [CNT_W-1:0] timeoutVal = '0;
  logic             busy, resumePulse, resumeCause;

  int nRun = 0;
  int nFail = 0;
  string curReq = "R1";

  always #(CLK_PERIOD/2) clk = ~clk;

  wait_resume_ctrl #(.SIG_W(SIG_W), .CNT_W(CNT_W)) u0 (
    .clk(clk), .rst(rst), .suspendReq(suspendReq), .watchSig(watchSig),
    .senseMask(senseMask), .condRefMask(condRefMask), .condUse(condUse),
    .condIn(condIn), .timeoutEn(timeoutEn), .timeoutVal(timeoutVal),
    .busy(busy), .resumePulse(resumePulse), .resumeCause(resumeCause)
  );

  // behavioural reference of the wait semantics
  bit mBusy, mPulse, mCause, mTmo;
  int mLeft;
  logic [SIG_W-1:0] mSeen;

  always @(posedge clk) begin
    if (rst) begin
      mBusy <= 0; mPulse <= 0; mCause <= 0;
    end else begin
      mPulse <= 0;
      if (!mBusy) begin
        if (suspendReq) begin
          mBusy <= 1; mSeen <= watchSig; mLeft <= int'(timeoutVal); mTmo <= timeoutEn;
        end
      end else begin
        logic [SIG_W-1:0] sel;
        bit ev, to;
        sel = (senseMask != 0) ? senseMask : condRefMask;
        ev  = (((watchSig ^ mSeen) & sel) != 0) && (!condUse || condIn);
        to  = mTmo && (mLeft == 0);
        mSeen <= watchSig;
        if (ev || to) begin
          mBusy <= 0; mPulse <= 1; mCause <= ev ? 1'b0 : 1'b1;
        end else if (mLeft > 0) begin
          mLeft <= mLeft - 1;
        end
      end
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    nRun++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // one clock, then compare with model at the falling edge
  task automatic step();
    @(posedge clk);
    @(negedge clk);
    chk(busy === mBusy, curReq, busy, mBusy);
    chk(resumePulse === mPulse, curReq, resumePulse, mPulse);
    if (mPulse) chk(resumeCause === mCause, curReq, resumeCause, mCause);
  endtask

  task automatic startWait(input logic [SIG_W-1:0] sm, input logic [SIG_W-1:0] cm,
                           input bit cu, input bit ci, input bit te, input int tv);
    senseMask = sm; condRefMask = cm; condUse = cu; condIn = ci;
    timeoutEn = te; timeoutVal = CNT_W'(tv); suspendReq = 1'b1;
    step();
    suspendReq = 1'b0;
    chk(busy === 1'b1, "R2", busy, 1);
  endtask

  // steps until pulse, returns count, or -1
  task automatic runUntilPulse(input int lim, output int n);
    n = -1;
    for (int i = 1; i <= lim; i++) begin
      step();
      if (resumePulse === 1'b1) begin n = i; break; end
    end
  endtask

  initial begin
    int n;
    #(CLK_PERIOD * 5000);
    nFail++; nRun++;
    $display("FAIL watchdog: actual 0 expected 1");
    $display("  [TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end

  initial begin
    int n;
    @(negedge clk); step(); step();
    rst = 1'b0;
    curReq = "R1";
    chk(busy === 0 && resumePulse === 0 && resumeCause === 0, "R1", busy, 0);

    // R3: plain event with true condition
    curReq = "R3";
    startWait(8'h01, 8'h00, 1, 1, 0, 0);
    watchSig[0] = 1'b1;
    step();
    chk(resumePulse === 1 && resumeCause === 0, "R3", resumeCause, 0);
    step();
    chk(resumePulse === 0 && busy === 0, "R12", resumePulse, 0);

    // R5: condition and level already true at start
    curReq = "R5";
    startWait(8'h01, 8'h00, 1, 1, 0, 0);
    runUntilPulse(12, n);
    chk(n == -1 && busy === 1, "R5", n, -1);
    curReq = "R4";
    condIn = 0; watchSig[0] = 0;
    runUntilPulse(3, n);
    chk(n == -1, "R4", n, -1);
    curReq = "R3";
    condIn = 1; watchSig[0] = 1;
    runUntilPulse(2, n);
    chk(n == 1 && resumeCause === 0, "R3", n, 1);
    step();

    // R6 and R13: unselected toggles, repeated suspend requests
    curReq = "R6";
    startWait(8'h01, 8'h00, 0, 0, 0, 0);
    suspendReq = 1;
    for (int i = 0; i < 6; i++) begin watchSig[3] = ~watchSig[3]; step(); end
    chk(resumePulse === 0 && busy === 1, "R6", busy, 1);
    suspendReq = 0;
    watchSig[0] = ~watchSig[0];
    runUntilPulse(2, n);
    chk(n == 1, "R6", n, 1);
    step();

    // R7 with R13: timeout of 5, reload attempt while busy
    curReq = "R7";
    startWait(8'h01, 8'h00, 1, 1, 1, 5);
    suspendReq = 1; timeoutVal = CNT_W'(2);
    runUntilPulse(20, n);
    suspendReq = 0;
    chk(n == 6, "R13", n, 6);
    chk(resumeCause === 1, "R7", resumeCause, 1);
    step();

    // R7: zero timeout
    startWait(8'h01, 8'h00, 1, 1, 1, 0);
    runUntilPulse(5, n);
    chk(n == 1 && resumeCause === 1, "R7", n, 1);
    step();

    // R8: no timeout, no events
    curReq = "R8";
    startWait(8'h00, 8'h00, 0, 0, 0, 3);
    runUntilPulse(40, n);
    chk(n == -1 && busy === 1, "R8", n, -1);
    rst = 1; step(); rst = 0; step();

    // R9: empty sense mask falls back to condition bits
    curReq = "R9";
    startWait(8'h00, 8'h04, 1, 1, 0, 0);
    watchSig[0] = ~watchSig[0]; step();
    chk(resumePulse === 0, "R9", resumePulse, 0);
    watchSig[2] = ~watchSig[2];
    runUntilPulse(2, n);
    chk(n == 1 && resumeCause === 0, "R9", n, 1);
    step();

    // R10: no condition present
    curReq = "R10";
    startWait(8'h10, 8'h00, 0, 0, 0, 0);
    watchSig[4] = ~watchSig[4];
    runUntilPulse(2, n);
    chk(n == 1, "R10", n, 1);
    step();

    // R11: event on expiry edge
    curReq = "R11";
    startWait(8'h02, 8'h00, 1, 1, 1, 2);
    step(); step();
    watchSig[1] = ~watchSig[1];
    step();
    chk(resumePulse === 1 && resumeCause === 0, "R11", resumeCause, 0);
    step();

    // random stimulus against the model
    curReq = "R12";
    for (int i = 0; i < 600; i++) begin
      suspendReq = ($urandom_range(3) == 0);
      watchSig   = ($urandom_range(2) == 0) ? SIG_W'($urandom) : watchSig;
      senseMask  = SIG_W'($urandom_range(3) == 0 ? 0 : $urandom);
      condRefMask = SIG_W'($urandom);
      condUse    = 1'($urandom);
      condIn     = 1'($urandom);
      timeoutEn  = 1'($urandom);
      timeoutVal = CNT_W'($urandom_range(8));
      step();
    end

    $display("  [TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end
endmodule